// File: doc/BRIEF.md
# Half-Rate Registered Stream Slice

This block sits between a producer and a consumer that both use a valid/ready handshake. It holds one item at a time and drives every output from a flip-flop. No combinational path runs from the consumer's ready back to the producer, and none runs from the producer's valid or data forward to the consumer. The cost is bandwidth: once an item has been taken in, the input stays closed until that item has left. A steady stream therefore moves at most one item every two cycles.

The upstream side may present an item at any time. It must hold `in_valid` and `in_data` until it sees `in_ready` high at a clock edge. The downstream side may raise or drop `out_ready` at any time. A transfer on either side happens only on an edge where valid and ready are both high. While `out_valid` is high and `out_ready` is low, the block keeps `out_valid` high and `out_data` unchanged.

An optional synchronous `flush` empties the slice. When the `HAS_FLUSH` parameter is 0, the pin is ignored.

Top module: `half_rate_slice`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: An input handshake (`in_valid` and `in_ready` high at an edge, no flush) makes `out_valid` 1 on the next cycle, with `out_data` equal to the accepted `in_data`.
- R3: While `out_valid` is 1 and `out_ready` is 0, and no flush is applied, `out_valid` stays 1 and `out_data` does not change.
- R4: An output handshake (`out_valid` and `out_ready` high at an edge) makes `out_valid` 0 and `in_ready` 1 on the next cycle.
- R5: `in_ready` and `out_valid` are never both 1. While `in_ready` is 0, `in_valid` and `in_data` are ignored: `out_data` keeps the stored item.
- R6: With the source always valid and the sink always ready, exactly one item leaves every two cycles.
- R7: With `HAS_FLUSH` = 1, asserting `flush` makes `out_valid` 0 and `in_ready` 1 on the next cycle. Flush wins over an input handshake in the same cycle: that item is dropped, and `out_data` keeps its previous value.
- R8: Items leave in the order they were accepted, with none lost and none duplicated, under any pattern of `out_ready`.
- R9: `in_ready` and `out_valid` change only at clock edges. Between edges they do not follow changes on `in_valid` or `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous empty request, used when HAS_FLUSH = 1 |
| in_valid | input | 1 | Upstream item present |
| in_ready | output | 1 | Slice can accept an item (registered) |
| in_data | input | DATA_W | Upstream item |
| out_valid | output | 1 | Stored item present (registered) |
| out_ready | input | 1 | Downstream takes the item |
| out_data | output | DATA_W | Stored item |

## Verification
A short cycle table covers these cases:
- an accept while the output is stalled;
- an attempted accept while the slice is full, which shows that input is ignored;
- a release followed by an immediate refill;
- a flush on its own;
- a flush that collides with an input handshake;
- a flush that collides with an output handshake.

These cases separate the priority of flush from the normal capture and release paths. A free-running stream into an always-ready sink checks the half-rate spacing. A long stream under a pseudo-random ready pattern, checked against a queue of accepted items, exposes any loss, duplication or reordering. Toggling the handshake inputs between clock edges shows whether any output follows them combinationally.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  typedef struct packed {
    logic full;
    logic open;
  } hrs_ctrl_t;

  localparam hrs_ctrl_t HRS_IDLE = '{full: 1'b0, open: 1'b1};
endpackage

// File: rtl/hrs_ctrl.sv
module hrs_ctrl
  import hrs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  input  logic give,
  output logic full,
  output logic open
);
  hrs_ctrl_t cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    if (clr) begin
      nxt = HRS_IDLE;
    end else if (take) begin
      nxt.full = 1'b1;
      nxt.open = 1'b0;
    end else if (give) begin
      nxt.full = 1'b0;
      nxt.open = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= HRS_IDLE;
    else        cur_q <= nxt;
  end

  assign full = cur_q.full;
  assign open = cur_q.open;
endmodule

// File: rtl/hrs_hold.sv
module hrs_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (load) q_r <= d;
  end

  assign q = q_r;
endmodule

// File: rtl/half_rate_slice.sv
module half_rate_slice #(
  parameter int DATA_W    = 8,
  parameter bit HAS_FLUSH = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic clr_eff;
  logic take, give;

  generate
    if (HAS_FLUSH) begin : g_flush
      assign clr_eff = flush;
    end else begin : g_noflush
      assign clr_eff = 1'b0;
    end
  endgenerate

  assign take = in_valid && in_ready;
  assign give = out_valid && out_ready;

  hrs_ctrl u_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr_eff),
    .take (take),
    .give (give),
    .full (out_valid),
    .open (in_ready)
  );

  hrs_hold #(.DATA_W(DATA_W)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .load (take && !clr_eff),
    .d    (in_data),
    .q    (out_data)
  );
endmodule

// File: rtl/half_rate_slice_chk.sv
module half_rate_slice_chk #(
  parameter int DATA_W    = 8,
  parameter bit HAS_FLUSH = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  logic fl;
  assign fl = HAS_FLUSH && flush;

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !fl) |=> (out_valid && out_data == $past(in_data)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !fl) |=> (out_valid && $stable(out_data)));

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !fl && !(out_valid && out_ready)) |=> $stable(out_data));

  assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fl |=> (!out_valid && in_ready));
endmodule

bind half_rate_slice half_rate_slice_chk #(.DATA_W(DATA_W), .HAS_FLUSH(HAS_FLUSH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/half_rate_slice_tb_top.sv
module half_rate_slice_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [DW-1:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  half_rate_slice #(.DATA_W(DW), .HAS_FLUSH(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // row fields: [20] in_valid [19:12] in_data [11] out_ready [10] flush
  //             [9] exp in_ready [8] exp out_valid [7:0] exp out_data
  localparam logic [20:0] VEC [10] = '{
    {1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA1},
    {1'b1, 8'hB2, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA1},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA1},
    {1'b1, 8'hC3, 1'b1, 1'b0, 1'b0, 1'b1, 8'hC3},
    {1'b1, 8'hD4, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC3},
    {1'b1, 8'hD4, 1'b1, 1'b0, 1'b0, 1'b1, 8'hD4},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'hD4},
    {1'b1, 8'hE5, 1'b0, 1'b1, 1'b1, 1'b0, 8'hD4},
    {1'b1, 8'hE5, 1'b0, 1'b0, 1'b0, 1'b1, 8'hE5},
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'hE5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] sent [256];
    int wr, rd, outs;
    logic [15:0] lfsr;
    logic v0, r0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_ready", in_ready, 1);
    check("R1 out_valid", out_valid, 0);

    // table walk: cases for R2 R3 R4 R5 R7
    for (int i = 0; i < 10; i++) begin
      in_valid  = VEC[i][20];
      in_data   = VEC[i][19:12];
      out_ready = VEC[i][11];
      flush     = VEC[i][10];
      @(negedge clk);
      check($sformatf("R2/R3/R4/R5/R7 row%0d in_ready", i), in_ready, VEC[i][9]);
      check($sformatf("R2/R3/R4/R5/R7 row%0d out_valid", i), out_valid, VEC[i][8]);
      check($sformatf("R2/R3/R4/R5/R7 row%0d out_data", i), out_data, VEC[i][7:0]);
    end
    in_valid = 1'b0; out_ready = 1'b0; flush = 1'b0;
    @(negedge clk);

    // R9: outputs must not follow inputs between edges
    v0 = out_valid; r0 = in_ready;
    in_valid = 1'b1; in_data = 8'h5A; #1;
    check("R9 in_ready stable", in_ready, r0);
    check("R9 out_valid stable", out_valid, v0);
    @(negedge clk);
    in_valid = 1'b0;
    v0 = out_valid; r0 = in_ready;
    out_ready = 1'b1; #1;
    check("R9 full in_ready stable", in_ready, r0);
    check("R9 full out_valid stable", out_valid, v0);
    @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);

    // R6: throughput with always-valid source and always-ready sink
    outs = 0;
    out_ready = 1'b1; in_valid = 1'b1;
    for (int c = 0; c < 40; c++) begin
      in_data = DW'(c);
      #1;
      if (out_valid && out_ready) outs++;
      @(negedge clk);
    end
    check("R6 items in 40 cycles", outs, 20);
    in_valid = 1'b0; out_ready = 1'b0;
    flush = 1'b1; @(negedge clk); flush = 1'b0; @(negedge clk);

    // R8: ordering under pseudo-random sink back-pressure
    wr = 0; rd = 0; lfsr = 16'hACE1;
    for (int c = 0; c < 600; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[3];
      in_valid = (wr < 200);
      in_data = DW'(wr * 7 + 3);
      #1;
      if (out_valid && out_ready) begin
        if (rd < wr) begin
          check("R8 order", out_data, sent[rd]);
        end else begin
          check("R8 no duplicate", 1, 0);
        end
        rd++;
      end
      if (in_valid && in_ready) begin
        sent[wr] = in_data;
        wr++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (4) begin
      #1;
      if (out_valid && out_ready) begin
        check("R8 order tail", out_data, sent[rd]);
        rd++;
      end
      @(negedge clk);
    end
    check("R8 all accepted", wr, 200);
    check("R8 none lost", rd, 200);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule